// File: doc/BRIEF.md
# Sigma-Delta Comparator Filter Unit

This block watches a 1-bit sigma-delta modulator bitstream and gives a fast, coarse measure of the signal behind it, for protection purposes. Each modulator bit is taken on a rising edge of the modulator clock, which is already qualified and synchronous to the system clock. The bits run through a sinc decimator whose order can be set to first, second or third. A fast second-order variant is also offered. The decimation ratio is set between 1 and 32. Every filtered sample is published with a one-cycle valid strobe.

Each filtered sample is compared against two high limits, two low limits and one crossing limit. The comparator results pass through a per-event glitch qualifier. The qualifier lets an event through only when enough recent samples agree. Qualified over-value and under-value events set sticky flags, which software clears by writing ones. The crossing comparator drives a level that follows the filtered signal across its limit. A downstream timer can measure duty cycle or frequency from that level. Configuration is meant to be changed while the unit is disabled. Limits and qualifier settings may also be changed while it runs.

Top module: `sdcf_top`

## Requirements
- R1: `order_sel` picks the filter: 0 first order, 1 second order, 2 fast second order, 3 third order. For an all-ones input, a settled sample equals R^K, where R is the ratio and K is the order (2 for the fast variant). An all-zeros input gives 0. A strictly alternating input with even R gives R^K/2. Any input gives at most R^K.
- R2: The ratio R is `osr_m1`+1, from 1 to 32. One `sample_vld` pulse comes per R modulator bits. A bit is the value of `mod_data` at the first system clock edge where `mod_clk` is seen high after being low. `sample_vld` is never high on two consecutive cycles.
- R3: After enable, the orders 1, 2 and 3 suppress their unsettled outputs. The first strobe comes after K·R bits and already carries the settled value. The fast variant strobes first after R bits. For an all-ones input, that first value is R(R+1)/2.
- R4: While `enable` is low, no strobe is issued, and the filter and qualifier state is cleared. `xing_lvl` is forced to 0. Sticky flags keep their value.
- R5: The raw over-value event for limit a or b is true when `sample` > `hi_thr_a` / `hi_thr_b`, compared as unsigned values.
- R6: The raw under-value event for limit a or b is true when `sample` < `lo_thr_a` / `lo_thr_b`, compared as unsigned values.
- R7: `xing_lvl` rises when the qualified "sample > `xing_thr`" event passes. It falls when the qualified "sample <= `xing_thr`" event passes. It changes only in the cycle after a strobe, or on disable.
- R8: A raw event passes when at least `need_m1`+1 of the last `win_m1`+1 filtered samples had it asserted, counting the current sample. When `need_m1` > `win_m1`, nothing passes.
- R9: The flags `ovr_a`, `ovr_b`, `und_a`, `und_b` set on a passing event and stay set. Each one clears on a 1 at `flag_clr` bit 0, 1, 2, 3 respectively. A set and a clear in the same cycle leave the flag set.
- R10: Flags and `xing_lvl` change one clock after the `sample_vld` cycle of the sample that caused the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Unit enable; low clears filter state |
| mod_clk | input | 1 | Qualified modulator clock |
| mod_data | input | 1 | Modulator bitstream |
| order_sel | input | 2 | Filter order code |
| osr_m1 | input | 5 | Decimation ratio minus one |
| hi_thr_a | input | 16 | First high limit |
| hi_thr_b | input | 16 | Second high limit |
| lo_thr_a | input | 16 | First low limit |
| lo_thr_b | input | 16 | Second low limit |
| xing_thr | input | 16 | Crossing limit |
| win_m1 | input | 4 | Qualifier window minus one |
| need_m1 | input | 4 | Qualifier hit count minus one |
| flag_clr | input | 4 | Write-one-to-clear for the sticky flags |
| sample | output | 16 | Filtered sample |
| sample_vld | output | 1 | One-cycle strobe for a new sample |
| ovr_a | output | 1 | Sticky over-value flag, limit a |
| ovr_b | output | 1 | Sticky over-value flag, limit b |
| und_a | output | 1 | Sticky under-value flag, limit a |
| und_b | output | 1 | Sticky under-value flag, limit b |
| xing_lvl | output | 1 | Crossing level |

## Verification
A software clear of a sticky flag can land in the same cycle as a new qualified event for that flag. The bench provokes this by holding a limit so that the raw event is true. It then drives the clear bit at the falling edge where it sees `sample_vld`, so the clear and the set reach the flag register on the same edge. The flag must read 1 afterwards. A plain clear with the raw event false must read 0, and the neighbouring flag must stay untouched.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;
  // filter order codes, decoded by the decimator
  typedef enum logic [1:0] {
    ORD_SINC1 = 2'd0,
    ORD_SINC2 = 2'd1,
    ORD_FAST2 = 2'd2,
    ORD_SINC3 = 2'd3
  } ord_t;

  localparam int MAX_STAGES = 3;
  // event indices for the qualifier bank
  localparam int EV_OVR_A  = 0;
  localparam int EV_OVR_B  = 1;
  localparam int EV_UND_A  = 2;
  localparam int EV_UND_B  = 3;
  localparam int EV_ABOVE  = 4;
  localparam int EV_BELOW  = 5;
  localparam int NUM_EV    = 6;
  localparam int NUM_FLAGS = 4;
endpackage

// File: rtl/sdcf_bit_capture.sv
module sdcf_bit_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_clk_i,
  input  logic mod_data_i,
  output logic bit_stb_o,
  output logic bit_val_o
);
  logic mclk_q;
  logic mclk_d;

  always_comb begin
    mclk_d    = mod_clk_i;
    bit_stb_o = mod_clk_i & ~mclk_q;
    bit_val_o = mod_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mclk_q <= 1'b0;
    else        mclk_q <= mclk_d;
  end
endmodule

// File: rtl/sdcf_sinc.sv
module sdcf_sinc import sdcf_pkg::*; #(
  parameter int ACC_W = 16,
  parameter int OSR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             bit_stb_i,
  input  logic             bit_val_i,
  input  logic [1:0]       order_i,
  input  logic [OSR_W-1:0] osr_m1_i,
  output logic [ACC_W-1:0] sample_o,
  output logic             vld_o
);
  localparam int NST = MAX_STAGES;

  logic [NST-1:0][ACC_W-1:0] integ_q, integ_d, integ_nx;
  logic [NST-1:0][ACC_W-1:0] comb_q, comb_d, comb_nx, diff;
  logic [OSR_W-1:0]          dec_q, dec_d;
  logic [1:0]                settle_q, settle_d;
  logic [ACC_W-1:0]          sample_q, sample_d;
  logic                      vld_q, vld_d;
  logic [ACC_W-1:0]          cin;
  logic [1:0]                last_st;
  logic [1:0]                skip;
  logic [ACC_W-1:0]          acc_i;
  logic [ACC_W-1:0]          acc_c;

  // integrator cascade, each stage fed by the updated value of the one before
  always_comb begin
    acc_i = {{(ACC_W-1){1'b0}}, bit_val_i};
    for (int s = 0; s < NST; s++) begin
      integ_nx[s] = integ_q[s] + acc_i;
      acc_i       = integ_nx[s];
    end
  end

  // order decode: tap point, output stage and number of discarded decimations
  always_comb begin
    case (ord_t'(order_i))
      ORD_SINC1: begin cin = integ_nx[0]; last_st = 2'd0; skip = 2'd0; end
      ORD_SINC2: begin cin = integ_nx[1]; last_st = 2'd1; skip = 2'd1; end
      ORD_FAST2: begin cin = integ_nx[1]; last_st = 2'd1; skip = 2'd0; end
      ORD_SINC3: begin cin = integ_nx[2]; last_st = 2'd2; skip = 2'd2; end
    endcase
  end

  // comb cascade at the decimated rate
  always_comb begin
    acc_c = cin;
    for (int s = 0; s < NST; s++) begin
      diff[s]    = acc_c - comb_q[s];
      comb_nx[s] = acc_c;
      acc_c      = diff[s];
    end
  end

  always_comb begin
    integ_d  = integ_q;
    comb_d   = comb_q;
    dec_d    = dec_q;
    settle_d = settle_q;
    sample_d = sample_q;
    vld_d    = 1'b0;
    if (!enable_i) begin
      integ_d  = '0;
      comb_d   = '0;
      dec_d    = '0;
      settle_d = '0;
      sample_d = '0;
    end else if (bit_stb_i) begin
      integ_d = integ_nx;
      if (dec_q == osr_m1_i) begin
        dec_d  = '0;
        comb_d = comb_nx;
        if (settle_q >= skip) begin
          sample_d = diff[last_st];
          vld_d    = 1'b1;
        end else begin
          settle_d = settle_q + 2'd1;
        end
      end else begin
        dec_d = dec_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q  <= '0;
      comb_q   <= '0;
      dec_q    <= '0;
      settle_q <= '0;
      sample_q <= '0;
      vld_q    <= 1'b0;
    end else begin
      integ_q  <= integ_d;
      comb_q   <= comb_d;
      dec_q    <= dec_d;
      settle_q <= settle_d;
      sample_q <= sample_d;
      vld_q    <= vld_d;
    end
  end

  assign sample_o = sample_q;
  assign vld_o    = vld_q;

  // R4
  no_strobe_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !vld_o);

  // R2
  strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o);
endmodule

// File: rtl/sdcf_glitch_qual.sv
module sdcf_glitch_qual #(
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             vld_i,
  input  logic             raw_i,
  input  logic [WIN_W-1:0] win_m1_i,
  input  logic [WIN_W-1:0] need_m1_i,
  output logic             pass_o
);
  localparam int HIST_W = 1 << WIN_W;

  logic [HIST_W-1:0] hist_q, hist_d, hist_nx, mask;
  int                hits;

  always_comb begin
    hist_nx = {hist_q[HIST_W-2:0], raw_i};
    for (int i = 0; i < HIST_W; i++) mask[i] = (i <= int'(win_m1_i));
    hits   = $countones(hist_nx & mask);
    pass_o = vld_i && (hits >= int'(need_m1_i) + 1);
    hist_d = hist_q;
    if (!enable_i)  hist_d = '0;
    else if (vld_i) hist_d = hist_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  // R8
  need_beyond_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (need_m1_i > win_m1_i) |-> !pass_o);
endmodule

// File: rtl/sdcf_top.sv
module sdcf_top import sdcf_pkg::*; #(
  parameter int ACC_W = 16,
  parameter int OSR_W = 5,
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mod_clk,
  input  logic             mod_data,
  input  logic [1:0]       order_sel,
  input  logic [OSR_W-1:0] osr_m1,
  input  logic [ACC_W-1:0] hi_thr_a,
  input  logic [ACC_W-1:0] hi_thr_b,
  input  logic [ACC_W-1:0] lo_thr_a,
  input  logic [ACC_W-1:0] lo_thr_b,
  input  logic [ACC_W-1:0] xing_thr,
  input  logic [WIN_W-1:0] win_m1,
  input  logic [WIN_W-1:0] need_m1,
  input  logic [3:0]       flag_clr,
  output logic [ACC_W-1:0] sample,
  output logic             sample_vld,
  output logic             ovr_a,
  output logic             ovr_b,
  output logic             und_a,
  output logic             und_b,
  output logic             xing_lvl
);
  logic                 bit_stb, bit_val;
  logic [NUM_EV-1:0]    raw, pass;
  logic [NUM_FLAGS-1:0] flags_q, flags_d;
  logic                 xing_q, xing_d;

  sdcf_bit_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .mod_clk_i  (mod_clk),
    .mod_data_i (mod_data),
    .bit_stb_o  (bit_stb),
    .bit_val_o  (bit_val)
  );

  sdcf_sinc #(.ACC_W(ACC_W), .OSR_W(OSR_W)) u_sinc (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (enable),
    .bit_stb_i (bit_stb),
    .bit_val_i (bit_val),
    .order_i   (order_sel),
    .osr_m1_i  (osr_m1),
    .sample_o  (sample),
    .vld_o     (sample_vld)
  );

  always_comb begin
    raw[EV_OVR_A] = sample > hi_thr_a;
    raw[EV_OVR_B] = sample > hi_thr_b;
    raw[EV_UND_A] = sample < lo_thr_a;
    raw[EV_UND_B] = sample < lo_thr_b;
    raw[EV_ABOVE] = sample > xing_thr;
    raw[EV_BELOW] = !(sample > xing_thr);
  end

  for (genvar e = 0; e < NUM_EV; e++) begin : g_qual
    sdcf_glitch_qual #(.WIN_W(WIN_W)) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable_i  (enable),
      .vld_i     (sample_vld),
      .raw_i     (raw[e]),
      .win_m1_i  (win_m1),
      .need_m1_i (need_m1),
      .pass_o    (pass[e])
    );
  end

  always_comb begin
    flags_d = (flags_q & ~flag_clr) | pass[NUM_FLAGS-1:0];
    xing_d  = xing_q;
    if (!enable)                        xing_d = 1'b0;
    else if (!xing_q && pass[EV_ABOVE]) xing_d = 1'b1;
    else if (xing_q && pass[EV_BELOW])  xing_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      xing_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      xing_q  <= xing_d;
    end
  end

  assign ovr_a    = flags_q[EV_OVR_A];
  assign ovr_b    = flags_q[EV_OVR_B];
  assign und_a    = flags_q[EV_UND_A];
  assign und_b    = flags_q[EV_UND_B];
  assign xing_lvl = xing_q;

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_a && !flag_clr[0]) |=> ovr_a);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[2] && !sample_vld) |=> !und_a);

  // R10
  flag_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_b) |-> $past(sample_vld));

  // R7
  xing_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !$stable(xing_lvl)) |-> $past(sample_vld));
endmodule

// File: tb/sdcf_top_bench.sv
module sdcf_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        mod_clk = 1'b0;
  logic        mod_data = 1'b0;
  logic [1:0]  order_sel = 2'd0;
  logic [4:0]  osr_m1 = 5'd0;
  logic [15:0] hi_thr_a = 16'd0, hi_thr_b = 16'd0, lo_thr_a = 16'd0, lo_thr_b = 16'd0;
  logic [15:0] xing_thr = 16'd0;
  logic [3:0]  win_m1 = 4'd0, need_m1 = 4'd0, flag_clr = 4'd0;
  logic [15:0] sample;
  logic        sample_vld, ovr_a, ovr_b, und_a, und_b, xing_lvl;

  int n_chk = 0;
  int n_fail = 0;
  int pat = 0;       // 0 ones, 1 zeros, 2 alternating, 3 random
  int bits_seen = 0;
  logic mc_prev = 1'b0;
  logic alt_bit = 1'b0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  sdcf_top u_sdcf_top (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mod_clk(mod_clk), .mod_data(mod_data),
    .order_sel(order_sel), .osr_m1(osr_m1), .hi_thr_a(hi_thr_a), .hi_thr_b(hi_thr_b),
    .lo_thr_a(lo_thr_a), .lo_thr_b(lo_thr_b), .xing_thr(xing_thr), .win_m1(win_m1),
    .need_m1(need_m1), .flag_clr(flag_clr), .sample(sample), .sample_vld(sample_vld),
    .ovr_a(ovr_a), .ovr_b(ovr_b), .und_a(und_a), .und_b(und_b), .xing_lvl(xing_lvl)
  );

  // bits accepted since enable, from the edge rule of R2
  always @(posedge clk) begin
    if (!enable) bits_seen <= 0;
    else if (mod_clk && !mc_prev) bits_seen <= bits_seen + 1;
    mc_prev <= mod_clk;
  end

  // modulator: 2 cycles low, 2 cycles high, data changes while low
  initial begin
    forever begin
      @(negedge clk);
      mod_clk = 1'b0;
      case (pat)
        0: mod_data = 1'b1;
        1: mod_data = 1'b0;
        2: begin alt_bit = ~alt_bit; mod_data = alt_bit; end
        default: mod_data = 1'($urandom_range(0, 1));
      endcase
      @(negedge clk);
      @(negedge clk);
      mod_clk = 1'b1;
      @(negedge clk);
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
  end

  function automatic int order_k(input int ord);
    return (ord == 0) ? 1 : ((ord == 3) ? 3 : 2);
  endfunction

  function automatic int ipow(input int r, input int k);
    int v = 1;
    for (int i = 0; i < k; i++) v = v * r;
    return v;
  endfunction

  function automatic int steady_val(input int ord, input int r, input int p);
    if (p == 1) return 0;
    if (p == 2) return ipow(r, order_k(ord)) / 2;
    return ipow(r, order_k(ord));
  endfunction

  function automatic logic [15:0] clampv(input int v);
    if (v < 0) return 16'd0;
    if (v > 65535) return 16'hffff;
    return 16'(v);
  endfunction

  task automatic wait_vld();
    do @(negedge clk); while (!sample_vld);
  endtask

  task automatic start(input int ord, input int r, input int p);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    order_sel = 2'(ord);
    osr_m1 = 5'(r - 1);
    pat = p;
    flag_clr = 4'hf;
    @(negedge clk);
    flag_clr = 4'h0;
    enable = 1'b1;
  endtask

  // one enable run: first strobe timing/value, comparator flags, steady value
  task automatic trial(input int ord, input int r, input int p);
    int k, first_exp, v;
    bit known;
    k = order_k(ord);
    known = 1'b1;
    if (ord == 2) begin
      first_exp = (p == 0) ? r * (r + 1) / 2 : 0;
      known = (p == 0) || (p == 1);
    end else begin
      first_exp = steady_val(ord, r, p);
      known = (p != 3);
    end
    start(ord, r, p);
    wait_vld();
    v = int'(sample);
    chk("R3 bits to first strobe", bits_seen, (ord == 2) ? r : k * r);
    if (known) chk("R1/R3 first value", v, first_exp);
    else chk("R1 bound", int'(v <= ipow(r, k)), 1);
    @(negedge clk);
    chk("R5 ovr_a", int'(ovr_a), int'(v > int'(hi_thr_a)));
    chk("R5 ovr_b", int'(ovr_b), int'(v > int'(hi_thr_b)));
    chk("R6 und_a", int'(und_a), int'(v < int'(lo_thr_a)));
    chk("R6 und_b", int'(und_b), int'(v < int'(lo_thr_b)));
    wait_vld();
    if (p == 3) chk("R1 bound", int'(int'(sample) <= ipow(r, k)), 1);
    else chk("R1 steady value", int'(sample), steady_val(ord, r, p));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk("reset sample_vld", int'(sample_vld), 0);
    chk("reset flags", int'({ovr_a, ovr_b, und_a, und_b, xing_lvl}), 0);
    chk("reset sample", int'(sample), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners, window of one sample
    hi_thr_a = 16'd0; hi_thr_b = 16'hffff; lo_thr_a = 16'hffff; lo_thr_b = 16'd0;
    trial(0, 1, 0);
    trial(3, 1, 0);
    trial(2, 1, 0);
    trial(3, 32, 0);
    trial(1, 32, 2);
    trial(2, 8, 0);
    trial(3, 6, 1);
    trial(0, 7, 3);

    // constrained random runs
    for (int t = 0; t < 24; t++) begin
      int ord, r, p, e;
      ord = $urandom_range(0, 3);
      p = $urandom_range(0, 3);
      r = $urandom_range(1, 32);
      if (p == 2 && (r % 2) != 0) r = r + 1;
      if (r > 32) r = 32;
      e = steady_val(ord, r, p);
      if (ord == 2 && p == 0) e = r * (r + 1) / 2;
      hi_thr_a = clampv(e + $urandom_range(0, 4) - 2);
      hi_thr_b = clampv(e + $urandom_range(0, 4) - 2);
      lo_thr_a = clampv(e + $urandom_range(0, 4) - 2);
      lo_thr_b = clampv(e + $urandom_range(0, 4) - 2);
      trial(ord, r, p);
    end

    // R8 qualifier: 3 hits out of 4, raw over-value always true (sample 4 > 0)
    hi_thr_a = 16'd0; hi_thr_b = 16'd100; lo_thr_a = 16'd0; lo_thr_b = 16'd0;
    win_m1 = 4'd3; need_m1 = 4'd2;
    start(0, 4, 0);
    wait_vld(); @(negedge clk);
    chk("R8 1st hit blocked", int'(ovr_a), 0);
    wait_vld(); @(negedge clk);
    chk("R8 2nd hit blocked", int'(ovr_a), 0);
    wait_vld(); @(negedge clk);
    chk("R8 3rd hit passes", int'(ovr_a), 1);
    chk("R5 ovr_b stays low", int'(ovr_b), 0);

    // R8 need beyond window never passes
    win_m1 = 4'd1; need_m1 = 4'd4;
    start(0, 4, 0);
    for (int i = 0; i < 5; i++) begin wait_vld(); end
    @(negedge clk);
    chk("R8 need over window", int'(ovr_a), 0);

    // R7 crossing level, R9 clears, R4 disable
    win_m1 = 4'd0; need_m1 = 4'd0;
    hi_thr_a = 16'd0; hi_thr_b = 16'd0; xing_thr = 16'd2;
    start(0, 4, 0);
    wait_vld();
    chk("R10 level before update", int'(xing_lvl), 0);
    @(negedge clk);
    chk("R7 level rises", int'(xing_lvl), 1);
    chk("R10 flag after strobe", int'(ovr_a), 1);
    xing_thr = 16'd10;
    hi_thr_a = 16'd100;
    wait_vld(); @(negedge clk);
    chk("R7 level falls", int'(xing_lvl), 0);
    chk("R9 sticky with raw false", int'(ovr_a), 1);
    flag_clr = 4'b0001;
    @(negedge clk);
    flag_clr = 4'b0000;
    chk("R9 clear ovr_a", int'(ovr_a), 0);
    chk("R9 ovr_b untouched", int'(ovr_b), 1);
    hi_thr_a = 16'd0;
    wait_vld();
    flag_clr = 4'b0001;
    @(negedge clk);
    flag_clr = 4'b0000;
    chk("R9 set wins over clear", int'(ovr_a), 1);
    xing_thr = 16'd1;
    wait_vld(); @(negedge clk);
    chk("R7 level high again", int'(xing_lvl), 1);
    enable = 1'b0;
    @(negedge clk);
    chk("R4 level cleared", int'(xing_lvl), 0);
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (sample_vld) seen++;
      end
      chk("R4 no strobe while off", seen, 0);
    end
    chk("R4 flags retained", int'(ovr_a && ovr_b), 1);

    summary();
  end
endmodule